// File: doc/BRIEF.md
# System Timestamp Counter

This block keeps a free-running 56-bit timestamp that advances only on cycles where a reference tick-enable input is high, so its rate is set by the reference and not by the system clock that samples it. Each tick adds a programmable step of 1 to 16 to the count. A step above 1 lets the count look as if it ran faster than the reference while keeping the reference's long-term accuracy.

Two 64-bit readouts are always available. The physical readout is the count. The virtual readout is the count minus a programmable offset, taken modulo 2^56. Both readouts are zero-extended to 64 bits.

Software controls the block through a write-only register port with a 3-bit address and 32-bit data. It can start and stop counting, load any count value in two 32-bit halves, set the offset in two halves, pick the step, and arm a mode in which an external debug-halt input freezes the count.

Top module: `tsc_counter_top`

## Requirements
- R1: While reset is high, and when it is released, the count is 0, counting is enabled, the step is 1, the offset is 0 and debug freezing is disarmed. Both readouts are therefore 0.
- R2: On each clock edge where tick_en is high and the count is neither stopped nor frozen, the count grows by the current step. On an edge where tick_en is low, the count does not change.
- R3: Address 0 is the control register. Bit 0 written as 0 stops counting and bit 0 written as 1 resumes it.
- R4: Control bit 1 arms debug freezing. While it is armed and dbg_halt is high, ticks are ignored. When it is disarmed, dbg_halt has no effect.
- R5: A write to address 1 replaces count bits 31:0 with wr_data. A write to address 2 replaces count bits 55:32 with wr_data[23:0]. Each write is visible on the readouts after that edge, and the other half of the count is left unchanged.
- R6: When a count write and an active tick fall on the same edge, the written value is kept and that tick is lost.
- R7: A write to address 5 sets the step. A value of 0 becomes 1, values from 1 to 16 are kept as written, and values above 16 become 16.
- R8: The count wraps modulo 2^56. For example, 2^56-2 plus a step of 3 gives 1.
- R9: Address 3 holds offset bits 31:0 and address 4 holds offset bits 63:32. Bits 55:0 of virt_cnt equal the count minus offset bits 55:0, modulo 2^56. Offset bits 63:56 have no effect on the result.
- R10: Bits 63:56 of phys_cnt and virt_cnt are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Reference tick, one count step per high cycle |
| dbg_halt | input | 1 | Debug-halt request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| phys_cnt | output | 64 | Physical readout, zero-extended count |
| virt_cnt | output | 64 | Virtual readout, count minus offset, zero-extended |

## Verification
The bound checker checks the following on every cycle:
- the count holds on cycles with no tick, while it is stopped, and while it is frozen by debug;
- each active tick adds exactly the current step;
- the step stays between 1 and 16;
- the gap between the physical and virtual readouts changes only when the offset is written.

Other behaviours need the bench's directed scenarios, because they depend on specific data values:
- write priority over a tick on the same edge;
- step clamping;
- replacement of one half of the count;
- wraparound at 2^56;
- the virtual readout going below zero;
- the unused top offset byte having no effect.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;
    localparam int CNT_W    = 56;
    localparam int BUS_W    = 32;
    localparam int OUT_W    = 64;
    localparam int ADDR_W   = 3;
    localparam int MULT_MAX = 16;
    localparam int MULT_W   = $clog2(MULT_MAX + 1);

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 3'd0,
        REG_CNT_LO = 3'd1,
        REG_CNT_HI = 3'd2,
        REG_OFS_LO = 3'd3,
        REG_OFS_HI = 3'd4,
        REG_STEP   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic              run;
        logic              halt_arm;
        logic [MULT_W-1:0] step;
    } ctl_t;

    typedef struct packed {
        logic             lo;
        logic             hi;
        logic [BUS_W-1:0] data;
    } load_t;

    function automatic logic [MULT_W-1:0] clamp_step(input logic [BUS_W-1:0] d);
        if (d == '0)
            return MULT_W'(1);
        else if (d > BUS_W'(MULT_MAX))
            return MULT_W'(MULT_MAX);
        else
            return d[MULT_W-1:0];
    endfunction
endpackage

// File: rtl/tsc_regs.sv
`timescale 1ns/1ps
module tsc_regs
    import tsc_pkg::*;
#(
    parameter int BUS_W = tsc_pkg::BUS_W,
    parameter int OFS_W = tsc_pkg::OUT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output ctl_t              ctl,
    output load_t             load,
    output logic [OFS_W-1:0]  offset
);
    localparam int OFS_HI_W = OFS_W - BUS_W;

    reg_addr_e sel;
    assign sel = reg_addr_e'(wr_addr);

    // Count loads go straight to the core in the same cycle.
    always_comb begin
        load.lo   = wr_en && (sel == REG_CNT_LO);
        load.hi   = wr_en && (sel == REG_CNT_HI);
        load.data = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.run      <= 1'b1;
            ctl.halt_arm <= 1'b0;
            ctl.step     <= MULT_W'(1);
            offset       <= '0;
        end else if (wr_en) begin
            case (sel)
                REG_CTRL: begin
                    ctl.run      <= wr_data[0];
                    ctl.halt_arm <= wr_data[1];
                end
                REG_STEP:   ctl.step <= clamp_step(wr_data);
                REG_OFS_LO: offset[BUS_W-1:0] <= wr_data;
                REG_OFS_HI: offset[OFS_W-1:BUS_W] <= wr_data[OFS_HI_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tsc_core.sv
`timescale 1ns/1ps
module tsc_core
    import tsc_pkg::*;
#(
    parameter int CNT_W = tsc_pkg::CNT_W,
    parameter int BUS_W = tsc_pkg::BUS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             dbg_halt,
    input  ctl_t             ctl,
    input  load_t            load,
    output logic [CNT_W-1:0] count
);
    localparam int HI_W = CNT_W - BUS_W;

    logic             advance;
    logic [CNT_W-1:0] step_ext;
    logic [BUS_W-1:0] unused_hi_data;

    assign advance        = ctl.run && tick_en && !(ctl.halt_arm && dbg_halt);
    assign step_ext       = CNT_W'(ctl.step);
    assign unused_hi_data = load.data;

    // A load replaces the increment on the same edge.
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load.lo)
            count[BUS_W-1:0] <= load.data;
        else if (load.hi)
            count[CNT_W-1:BUS_W] <= load.data[HI_W-1:0];
        else if (advance)
            count <= count + step_ext;
    end
endmodule

// File: rtl/tsc_view.sv
`timescale 1ns/1ps
module tsc_view #(
    parameter int CNT_W = tsc_pkg::CNT_W,
    parameter int OUT_W = tsc_pkg::OUT_W
) (
    input  logic [CNT_W-1:0] count,
    input  logic [OUT_W-1:0] offset,
    output logic [OUT_W-1:0] phys,
    output logic [OUT_W-1:0] virt
);
    logic [CNT_W-1:0] virt_raw;
    logic [OUT_W-1:0] unused_ofs;

    assign unused_ofs = offset;
    assign virt_raw   = count - offset[CNT_W-1:0];

    generate
        if (OUT_W > CNT_W) begin : g_pad
            assign phys = {{(OUT_W-CNT_W){1'b0}}, count};
            assign virt = {{(OUT_W-CNT_W){1'b0}}, virt_raw};
        end else begin : g_flat
            assign phys = count;
            assign virt = virt_raw;
        end
    endgenerate
endmodule

// File: rtl/tsc_counter_top.sv
`timescale 1ns/1ps
module tsc_counter_top
    import tsc_pkg::*;
#(
    parameter int CNT_W = tsc_pkg::CNT_W,
    parameter int BUS_W = tsc_pkg::BUS_W,
    parameter int OUT_W = tsc_pkg::OUT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              dbg_halt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [OUT_W-1:0]  phys_cnt,
    output logic [OUT_W-1:0]  virt_cnt
);
    ctl_t              ctl;
    load_t             load;
    logic [OUT_W-1:0]  offset;
    logic [CNT_W-1:0]  count;
    logic              cnt_run;
    logic              cnt_halt_arm;
    logic [MULT_W-1:0] cnt_step;

    assign cnt_run      = ctl.run;
    assign cnt_halt_arm = ctl.halt_arm;
    assign cnt_step     = ctl.step;

    tsc_regs #(.BUS_W(BUS_W), .OFS_W(OUT_W)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctl(ctl), .load(load), .offset(offset)
    );

    tsc_core #(.CNT_W(CNT_W), .BUS_W(BUS_W)) core_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .dbg_halt(dbg_halt),
        .ctl(ctl), .load(load), .count(count)
    );

    tsc_view #(.CNT_W(CNT_W), .OUT_W(OUT_W)) view_i (
        .count(count), .offset(offset), .phys(phys_cnt), .virt(virt_cnt)
    );
endmodule

// File: rtl/tsc_counter_chk.sv
`timescale 1ns/1ps
module tsc_counter_chk
    import tsc_pkg::*;
#(
    parameter int CNT_W = tsc_pkg::CNT_W,
    parameter int OUT_W = tsc_pkg::OUT_W
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              dbg_halt,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [OUT_W-1:0]  phys_cnt,
    input logic [OUT_W-1:0]  virt_cnt,
    input logic              cnt_run,
    input logic              cnt_halt_arm,
    input logic [MULT_W-1:0] cnt_step
);
    logic             cnt_wr;
    logic             ofs_wr;
    logic [CNT_W-1:0] phys_low;
    logic [CNT_W-1:0] gap;

    assign cnt_wr   = wr_en && (wr_addr == REG_CNT_LO || wr_addr == REG_CNT_HI);
    assign ofs_wr   = wr_en && (wr_addr == REG_OFS_LO || wr_addr == REG_OFS_HI);
    assign phys_low = phys_cnt[CNT_W-1:0];
    assign gap      = phys_cnt[CNT_W-1:0] - virt_cnt[CNT_W-1:0];

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (phys_cnt == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !wr_en) |=> $stable(phys_cnt));

    // R2
    step_add_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && cnt_run && !(cnt_halt_arm && dbg_halt) && !cnt_wr)
        |=> (phys_low == $past(phys_low + CNT_W'(cnt_step))));

    // R3
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cnt_run && !cnt_wr) |=> $stable(phys_cnt));

    // R4
    debug_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_halt_arm && dbg_halt && !cnt_wr) |=> $stable(phys_cnt));

    // R7
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_step >= MULT_W'(1)) && (cnt_step <= MULT_W'(MULT_MAX)));

    // R9
    view_gap_chk: assert property (@(posedge clk) disable iff (rst)
        !ofs_wr |=> $stable(gap));
endmodule

bind tsc_counter_top tsc_counter_chk #(.CNT_W(CNT_W), .OUT_W(OUT_W)) chk_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .dbg_halt(dbg_halt),
    .wr_en(wr_en), .wr_addr(wr_addr), .phys_cnt(phys_cnt), .virt_cnt(virt_cnt),
    .cnt_run(cnt_run), .cnt_halt_arm(cnt_halt_arm), .cnt_step(cnt_step)
);

// File: tb/tsc_counter_top_tb.sv
`timescale 1ns/1ps
module tsc_counter_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [63:0] phys_cnt;
    logic [63:0] virt_cnt;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tsc_counter_top dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .dbg_halt(dbg_halt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .phys_cnt(phys_cnt), .virt_cnt(virt_cnt)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; tick_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n, input logic tk);
        @(negedge clk);
        tick_en = tk;
        for (int i = 0; i < n; i++) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic load_cnt(input logic [55:0] v);
        wr(3'd1, v[31:0]);
        wr(3'd2, {8'h00, v[55:32]});
    endtask

    task automatic t_reset();
        check("R1 phys after reset", phys_cnt, 64'd0);
        check("R1 virt after reset", virt_cnt, 64'd0);
    endtask

    task automatic t_ticks();
        run(5, 1'b1);
        check("R1/R2 default step 1 over 5 ticks", phys_cnt, 64'd5);
        run(3, 1'b0);
        check("R2 no tick holds", phys_cnt, 64'd5);
    endtask

    task automatic t_enable();
        wr(3'd0, 32'h0);
        run(3, 1'b1);
        check("R3 stopped", phys_cnt, 64'd5);
        wr(3'd0, 32'h1);
        run(2, 1'b1);
        check("R3 resumed", phys_cnt, 64'd7);
    endtask

    task automatic t_halt();
        dbg_halt = 1'b1;
        run(2, 1'b1);
        check("R4 dbg_halt ignored when disarmed", phys_cnt, 64'd9);
        wr(3'd0, 32'h3);
        run(3, 1'b1);
        check("R4 frozen while armed and halted", phys_cnt, 64'd9);
        dbg_halt = 1'b0;
        run(1, 1'b1);
        check("R4 resumes after halt drops", phys_cnt, 64'd10);
        wr(3'd0, 32'h1);
    endtask

    task automatic t_step();
        load_cnt(56'd0);
        wr(3'd5, 32'd3);
        run(4, 1'b1);
        check("R7 step 3", phys_cnt, 64'd12);
        wr(3'd5, 32'd0);
        run(2, 1'b1);
        check("R7 step 0 clamps to 1", phys_cnt, 64'd14);
        wr(3'd5, 32'd40);
        run(1, 1'b1);
        check("R7 step 40 clamps to 16", phys_cnt, 64'd30);
        wr(3'd5, 32'd16);
        run(1, 1'b1);
        check("R7 step 16 kept", phys_cnt, 64'd46);
        wr(3'd5, 32'd1);
    endtask

    task automatic t_load();
        wr(3'd1, 32'hDEADBEEF);
        check("R5 low half load", phys_cnt, 64'h0000_0000_DEAD_BEEF);
        wr(3'd2, 32'hFFAB_CDEF);
        check("R5/R10 high half load", phys_cnt, 64'h00AB_CDEF_DEAD_BEEF);
        wr(3'd1, 32'h0000_0010);
        check("R5 low load keeps high half", phys_cnt, 64'h00AB_CDEF_0000_0010);
    endtask

    task automatic t_priority();
        load_cnt(56'd0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'd100; tick_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
        check("R6 write wins over tick", phys_cnt, 64'd100);
        run(1, 1'b1);
        check("R6 tick after write", phys_cnt, 64'd101);
    endtask

    task automatic t_wrap();
        load_cnt(56'hFF_FFFF_FFFF_FFFE);
        wr(3'd5, 32'd3);
        run(1, 1'b1);
        check("R8/R10 wrap modulo 2^56", phys_cnt, 64'd1);
        wr(3'd5, 32'd1);
    endtask

    task automatic t_virt();
        load_cnt(56'd1000);
        wr(3'd3, 32'd400);
        check("R9 virt = phys - offset", virt_cnt, 64'd600);
        wr(3'd4, 32'hFF00_0000);
        check("R9 offset top byte ignored", virt_cnt, 64'd600);
        wr(3'd3, 32'd5000);
        check("R9/R10 virt wraps below zero", virt_cnt, 64'h00FF_FFFF_FFFF_F060);
        run(4, 1'b1);
        check("R9 virt tracks ticks", virt_cnt, 64'h00FF_FFFF_FFFF_F064);
        check("R10 phys top byte zero", {56'd0, phys_cnt[63:56]}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ticks();
        t_enable();
        t_halt();
        t_step();
        t_load();
        t_priority();
        t_wrap();
        t_virt();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule